// File: doc/BRIEF.md
# Dataflow Operand Tag Matcher

This block is one dataflow processing element that holds a single two-input instruction. Operand tokens arrive on two channels, one per instruction input (channel A is the left operand, channel B the right operand). Each token carries a wave tag and a data word. A token whose partner has not yet arrived is parked in a small matching table keyed by its tag; when the partner with an equal tag shows up, the element fires at once. It computes the configured operation and places one result token, carrying the same tag, into an output slot. That slot is offered to each enabled consumer over its own valid/ready link.

No program counter or fetch sequencing is involved: firing is driven purely by operand arrival. Several waves may be in flight together, and they complete in whatever order their operands finish. A wave-advance opcode turns the element into a tag incrementer. Every token then fires on its own, passing its data through and emitting the tag plus one, which lets a loop hand its values to the next wave.

The opcode and the consumer enable mask are static. They are captured on every clock edge while reset is held and stay frozen afterwards. At most one input token is accepted per cycle. Results are never dropped. A busy output slot stalls any token that would fire.

Top module: `df_match_pe`

## Requirements
- R1: After reset, no result is offered on any consumer link and both input channels show ready, because the table is empty and the output slot is free.
- R2: When the left and right operands with equal tags have both been accepted, exactly one result carrying that tag is produced. Its data is computed from the captured opcode as follows: 0 gives left+right, 1 gives left-right (modulo 2^DATA_W), 2 gives left AND right, 3 gives left OR right, and codes 5 to 7 behave as 0.
- R3: Operands with different tags are never paired. Waves complete in the order their second operand arrives, regardless of the order their first operands arrived.
- R4: The result becomes valid on the enabled consumer links in the cycle right after the completing token is accepted.
- R5: With every table entry (ENTRIES, default 4) holding an unmatched operand, a token whose tag matches no entry sees ready low. A token that completes a stored entry is still accepted.
- R6: A second token for a tag and port that is already stored is held with ready low until that entry fires. It is then accepted into a fresh entry, and the earlier token's data is used for the first result.
- R7: Bit i of the captured consumer mask enables consumer link i. Each enabled link presents every result exactly once, and a disabled link never asserts valid.
- R8: While any enabled link has not yet taken the current result, that result's tag and data stay unchanged, and a token that would fire sees ready low.
- R9: With opcode 4 (wave-advance), every token fires alone, whether it arrives on the left or right channel. The result carries the token's tag plus one, modulo 2^TAG_W, and its data unchanged.
- R10: When both channels could be accepted in the same cycle, channel A is taken and channel B shows ready low.
- R11: The opcode and consumer mask are sampled only while reset is asserted. Changing those inputs after reset has no effect on results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is captured while low |
| cfg_op | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 wave-advance |
| cfg_dest | input | NDEST | Consumer enable mask, bit i for link i |
| opa_valid | input | 1 | Left operand token valid |
| opa_ready | output | 1 | Left operand token accepted this cycle if valid |
| opa_tag | input | TAG_W | Left operand wave tag |
| opa_data | input | DATA_W | Left operand data |
| opb_valid | input | 1 | Right operand token valid |
| opb_ready | output | 1 | Right operand token accepted this cycle if valid |
| opb_tag | input | TAG_W | Right operand wave tag |
| opb_data | input | DATA_W | Right operand data |
| res_valid | output | NDEST | Per-consumer result valid |
| res_ready | input | NDEST | Per-consumer result ready |
| res_tag | output | TAG_W | Result wave tag |
| res_data | output | DATA_W | Result data |

## Verification
The matcher is driven with operand pairs whose right halves arrive in an order different from their left halves, so pairing by tag is distinguished from pairing by arrival order. Each of the four arithmetic opcodes is run with operands whose add, sub, and and or results all differ, so a wrong operation or swapped operands shows up. Filling all entries with single operands, repeating an already stored tag and port, and presenting both channels in one cycle exercise the full table, duplicate holding and channel priority. A phase with consumer ready held low separates a stalled slot from a dropped or repeated token. Wave-advance is run with the largest tag to expose wraparound, and with a single-consumer mask that must keep the other link silent.

// File: rtl/df_pkg.sv
package df_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_WADV = 3'd4
   } df_op_e;
endpackage

// File: rtl/df_alu.sv
module df_alu #(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   import df_pkg::*;

   always_comb begin
      unique case (op)
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         default: y = a + b;
      endcase
   end
endmodule

// File: rtl/df_match_table.sv
module df_match_table #(
   parameter  int ENTRIES = 4,
   parameter  int TAG_W   = 8,
   parameter  int DATA_W  = 32,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  lk_tag   [2],
   output logic              lk_hit   [2],
   output logic              lk_dup   [2],
   output logic [IDX_W-1:0]  lk_idx   [2],
   output logic [DATA_W-1:0] lk_other [2],
   output logic              free_ok,
   input  logic              upd_en,
   input  logic              upd_port,
   input  logic              upd_hit,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [TAG_W-1:0]  upd_tag,
   input  logic [DATA_W-1:0] upd_data
);
   logic [1:0]        vld_q [ENTRIES];
   logic [TAG_W-1:0]  tag_q [ENTRIES];
   logic [DATA_W-1:0] dat_q [ENTRIES][2];
   logic [IDX_W-1:0]  free_idx;

   // one associative lookup per input channel
   for (genvar ch = 0; ch < 2; ch++) begin : g_look
      logic             hit;
      logic [IDX_W-1:0] idx;
      always_comb begin
         hit = 1'b0;
         idx = '0;
         for (int e = 0; e < ENTRIES; e++) begin
            if ((|vld_q[e]) && (tag_q[e] == lk_tag[ch])) begin
               hit = 1'b1;
               idx = IDX_W'(e);
            end
         end
      end
      assign lk_hit[ch]   = hit;
      assign lk_idx[ch]   = idx;
      assign lk_dup[ch]   = hit && vld_q[idx][ch];
      assign lk_other[ch] = dat_q[idx][1-ch];
   end

   // lowest empty entry wins
   always_comb begin
      free_ok  = 1'b0;
      free_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (vld_q[e] == 2'b00) begin
            free_ok  = 1'b1;
            free_idx = IDX_W'(e);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) vld_q[e] <= 2'b00;
      end else if (upd_en) begin
         if (upd_hit) vld_q[upd_idx]           <= 2'b00;
         else         vld_q[free_idx][upd_port] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en && !upd_hit) begin
         tag_q[free_idx]           <= upd_tag;
         dat_q[free_idx][upd_port] <= upd_data;
      end
   end
endmodule

// File: rtl/df_fanout.sv
module df_fanout #(
   parameter int NDEST  = 2,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NDEST-1:0]  ld_mask,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [NDEST-1:0]  res_ready,
   output logic [NDEST-1:0]  res_valid,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_data,
   output logic              slot_free
);
   logic [NDEST-1:0] pend_q;

   for (genvar g = 0; g < NDEST; g++) begin : g_link
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            pend_q[g] <= 1'b0;
         else if (load)         pend_q[g] <= ld_mask[g];
         else if (res_ready[g]) pend_q[g] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         res_tag  <= ld_tag;
         res_data <= ld_data;
      end
   end

   assign res_valid = pend_q;
   assign slot_free = ~|(pend_q & ~res_ready);
endmodule

// File: rtl/df_match_pe.sv
module df_match_pe #(
   parameter int ENTRIES = 4,
   parameter int NDEST   = 2,
   parameter int TAG_W   = 8,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_op,
   input  logic [NDEST-1:0]  cfg_dest,
   input  logic              opa_valid,
   output logic              opa_ready,
   input  logic [TAG_W-1:0]  opa_tag,
   input  logic [DATA_W-1:0] opa_data,
   input  logic              opb_valid,
   output logic              opb_ready,
   input  logic [TAG_W-1:0]  opb_tag,
   input  logic [DATA_W-1:0] opb_data,
   output logic [NDEST-1:0]  res_valid,
   input  logic [NDEST-1:0]  res_ready,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_data
);
   import df_pkg::*;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 1) begin : g_bad_entries
      $error("df_match_pe: ENTRIES must be at least 1");
   end
   if (NDEST < 1) begin : g_bad_ndest
      $error("df_match_pe: NDEST must be at least 1");
   end
   if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("df_match_pe: TAG_W and DATA_W must be positive");
   end

   // static configuration, captured while reset is held
   logic [2:0]       op_q;
   logic [NDEST-1:0] dest_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q   <= cfg_op;
         dest_q <= cfg_dest;
      end
   end
   logic wadv;
   assign wadv = (op_q == OP_WADV);

   logic [TAG_W-1:0]  lk_tag   [2];
   logic              lk_hit   [2];
   logic              lk_dup   [2];
   logic [IDX_W-1:0]  lk_idx   [2];
   logic [DATA_W-1:0] lk_other [2];
   logic              free_ok, slot_free;
   logic              can      [2];

   assign lk_tag[0] = opa_tag;
   assign lk_tag[1] = opb_tag;

   for (genvar c = 0; c < 2; c++) begin : g_can
      assign can[c] = wadv ? slot_free
                    : (lk_hit[c] ? (!lk_dup[c] && slot_free) : free_ok);
   end

   // channel A has priority; one token per cycle
   logic acc_a, acc_b, acc, sel, fire;
   assign opa_ready = can[0];
   assign opb_ready = can[1] && !(opa_valid && can[0]);
   assign acc_a     = opa_valid && opa_ready;
   assign acc_b     = opb_valid && opb_ready;
   assign acc       = acc_a || acc_b;
   assign sel       = !acc_a;

   logic [TAG_W-1:0]  s_tag;
   logic [DATA_W-1:0] s_data, opnd_l, opnd_r, alu_y;
   assign s_tag  = sel ? opb_tag  : opa_tag;
   assign s_data = sel ? opb_data : opa_data;
   assign opnd_l = sel ? lk_other[1] : opa_data;
   assign opnd_r = sel ? opb_data    : lk_other[0];
   assign fire   = acc && (wadv || lk_hit[sel]);

   df_alu #(.DATA_W(DATA_W)) u_alu (
      .op(op_q), .a(opnd_l), .b(opnd_r), .y(alu_y)
   );

   df_match_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_tag   (lk_tag),
      .lk_hit   (lk_hit),
      .lk_dup   (lk_dup),
      .lk_idx   (lk_idx),
      .lk_other (lk_other),
      .free_ok  (free_ok),
      .upd_en   (acc && !wadv),
      .upd_port (sel),
      .upd_hit  (lk_hit[sel]),
      .upd_idx  (lk_idx[sel]),
      .upd_tag  (s_tag),
      .upd_data (s_data)
   );

   df_fanout #(.NDEST(NDEST), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (fire),
      .ld_mask   (dest_q),
      .ld_tag    (wadv ? TAG_W'(s_tag + 1'b1) : s_tag),
      .ld_data   (wadv ? s_data : alu_y),
      .res_ready (res_ready),
      .res_valid (res_valid),
      .res_tag   (res_tag),
      .res_data  (res_data),
      .slot_free (slot_free)
   );
endmodule

// File: rtl/df_match_pe_chk.sv
module df_match_pe_chk #(
   parameter int NDEST  = 2,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              opa_valid,
   input logic              opa_ready,
   input logic              opb_ready,
   input logic              fire,
   input logic [NDEST-1:0]  dest_q,
   input logic [NDEST-1:0]  res_valid,
   input logic [NDEST-1:0]  res_ready,
   input logic [TAG_W-1:0]  res_tag,
   input logic [DATA_W-1:0] res_data
);
   // R4
   fire_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (res_valid == $past(dest_q)));

   // R7
   dest_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid & ~dest_q) == '0);

   // R8
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(res_valid & ~res_ready)) |=> ($stable(res_tag) && $stable(res_data)));

   // R8
   no_fire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(res_valid & ~res_ready)) |-> !fire);

   // R10
   a_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opa_valid && opa_ready) |-> !opb_ready);
endmodule

bind df_match_pe df_match_pe_chk #(.NDEST(NDEST), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opa_valid (opa_valid),
   .opa_ready (opa_ready),
   .opb_ready (opb_ready),
   .fire      (fire),
   .dest_q    (dest_q),
   .res_valid (res_valid),
   .res_ready (res_ready),
   .res_tag   (res_tag),
   .res_data  (res_data)
);

// File: tb/df_match_pe_tb_top.sv
module df_match_pe_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NDEST = 2, TAG_W = 8, DATA_W = 32, ENTRIES = 4;
   localparam int WDOG = 100000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] cfg_op = 3'd0;
   logic [NDEST-1:0] cfg_dest = '1;
   logic opa_valid = 1'b0, opb_valid = 1'b0;
   logic opa_ready, opb_ready;
   logic [TAG_W-1:0] opa_tag = '0, opb_tag = '0;
   logic [DATA_W-1:0] opa_data = '0, opb_data = '0;
   logic [NDEST-1:0] res_valid;
   logic [NDEST-1:0] res_ready = '1;
   logic [TAG_W-1:0] res_tag;
   logic [DATA_W-1:0] res_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   df_match_pe #(.ENTRIES(ENTRIES), .NDEST(NDEST), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .cfg_dest(cfg_dest),
      .opa_valid(opa_valid), .opa_ready(opa_ready), .opa_tag(opa_tag), .opa_data(opa_data),
      .opb_valid(opb_valid), .opb_ready(opb_ready), .opb_tag(opb_tag), .opb_data(opb_data),
      .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data)
   );

   int n_chk = 0, n_fail = 0;
   string cur_req = "R2";
   logic [2:0] op_b = 3'd0;
   logic [NDEST-1:0] dest_b = '1;
   logic [39:0] exp_q0[$];
   logic [39:0] exp_q1[$];
   logic mv [2][256];
   logic [DATA_W-1:0] md [2][256];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DATA_W-1:0] ref_op(input logic [2:0] op, input logic [DATA_W-1:0] l, r);
      case (op)
         3'd1: return l - r;
         3'd2: return l & r;
         3'd3: return l | r;
         default: return l + r;
      endcase
   endfunction

   function automatic void push_exp(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
      if (dest_b[0]) exp_q0.push_back({t, d});
      if (dest_b[1]) exp_q1.push_back({t, d});
   endfunction

   function automatic void model_take(input int ch, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] l, r;
      if (op_b == 3'd4) push_exp(TAG_W'(t + 1), d);
      else if (mv[1-ch][t]) begin
         l = (ch == 0) ? d : md[0][t];
         r = (ch == 1) ? d : md[1][t];
         push_exp(t, ref_op(op_b, l, r));
         mv[1-ch][t] = 1'b0;
      end else begin
         mv[ch][t] = 1'b1;
         md[ch][t] = d;
      end
   endfunction

   // scoreboard monitor: outputs first, then input handshakes
   always @(negedge clk) begin
      #3;
      if (rst_n) begin
         for (int i = 0; i < NDEST; i++) begin
            if (res_valid[i] && !dest_b[i])
               chk(1'b0, "R7 disabled link valid", 64'(res_valid), 64'(dest_b));
            if (res_valid[i] && res_ready[i]) begin
               logic [39:0] got, exp;
               got = {res_tag, res_data};
               if ((i == 0 && exp_q0.size() == 0) || (i == 1 && exp_q1.size() == 0))
                  chk(1'b0, {cur_req, " R7 unexpected result"}, 64'(got), 64'd0);
               else begin
                  exp = (i == 0) ? exp_q0.pop_front() : exp_q1.pop_front();
                  chk(got == exp, {cur_req, " R3 result"}, 64'(got), 64'(exp));
               end
            end
         end
         if (opa_valid && opa_ready) model_take(0, opa_tag, opa_data);
         if (opb_valid && opb_ready) model_take(1, opb_tag, opb_data);
      end
   end

   task automatic present(input int ch, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
      @(negedge clk);
      if (ch == 0) begin opa_valid = 1'b1; opa_tag = t; opa_data = d; end
      else         begin opb_valid = 1'b1; opb_tag = t; opb_data = d; end
   endtask

   task automatic wait_accept(input int ch);
      #2;
      while (!((ch == 0) ? opa_ready : opb_ready)) begin
         @(negedge clk); #2;
      end
      @(posedge clk); #1;
      if (ch == 0) opa_valid = 1'b0; else opb_valid = 1'b0;
   endtask

   task automatic send(input int ch, input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
      present(ch, t, d);
      wait_accept(ch);
   endtask

   task automatic do_reset(input logic [2:0] op, input logic [NDEST-1:0] dm);
      @(negedge clk);
      rst_n = 1'b0; opa_valid = 1'b0; opb_valid = 1'b0; res_ready = '1;
      cfg_op = op; cfg_dest = dm; op_b = op; dest_b = dm;
      for (int c = 0; c < 2; c++) for (int t = 0; t < 256; t++) mv[c][t] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain(input string req);
      for (int k = 0; k < 50 && (exp_q0.size() + exp_q1.size()) != 0; k++) @(negedge clk);
      @(negedge clk);
      chk(exp_q0.size() == 0 && exp_q1.size() == 0, {req, " all results delivered"},
          64'(exp_q0.size() + exp_q1.size()), 64'd0);
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WDOG, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset(3'd0, 2'b11);
      #2;
      chk(res_valid == '0, "R1 no result after reset", 64'(res_valid), 64'd0);
      chk(opa_ready && opb_ready, "R1 ready after reset", {opa_ready, opb_ready}, 64'd3);

      // R2/R3 across the four arithmetic opcodes, out-of-order completion
      for (int op = 0; op < 4; op++) begin
         do_reset(3'(op), 2'b11);
         cur_req = "R2";
         send(0, 8'd5, 32'h0000_00F0);
         send(0, 8'd6, 32'h1234_5678);
         send(1, 8'd6, 32'h0F0F_0F0F);
         send(1, 8'd5, 32'h0000_0139);
         send(0, 8'd7, 32'd3);
         send(1, 8'd7, 32'd9);
         drain("R2");
      end

      // R4 latency, R11 configuration frozen after reset
      do_reset(3'd0, 2'b11);
      cfg_op = 3'd2; cfg_dest = 2'b00;
      cur_req = "R11";
      send(0, 8'd50, 32'd100);
      send(1, 8'd50, 32'd23);
      @(negedge clk); #1;
      chk(res_valid == 2'b11, "R4 valid one cycle after completion", 64'(res_valid), 64'd3);
      drain("R11");

      // R5 full table
      cur_req = "R5";
      send(0, 8'd10, 32'd1);
      send(0, 8'd11, 32'd2);
      send(0, 8'd12, 32'd3);
      send(0, 8'd13, 32'd4);
      present(0, 8'd14, 32'd5);
      #2;
      chk(opa_ready == 1'b0, "R5 new tag blocked when full", 64'(opa_ready), 64'd0);
      opa_valid = 1'b0;
      present(1, 8'd12, 32'd30);
      #2;
      chk(opb_ready == 1'b1, "R5 completing token accepted when full", 64'(opb_ready), 64'd1);
      wait_accept(1);
      send(0, 8'd14, 32'd5);
      send(1, 8'd10, 32'd10);
      send(1, 8'd11, 32'd20);
      send(1, 8'd13, 32'd40);
      send(1, 8'd14, 32'd50);
      drain("R5");

      // R6 duplicate tag and port held
      cur_req = "R6";
      send(0, 8'd20, 32'd1000);
      present(0, 8'd20, 32'd2000);
      #2;
      chk(opa_ready == 1'b0, "R6 duplicate held", 64'(opa_ready), 64'd0);
      send(1, 8'd20, 32'd7);
      wait_accept(0);
      send(1, 8'd20, 32'd8);
      drain("R6");

      // R10 channel priority
      cur_req = "R10";
      @(negedge clk);
      opa_valid = 1'b1; opa_tag = 8'd40; opa_data = 32'd400;
      opb_valid = 1'b1; opb_tag = 8'd41; opb_data = 32'd410;
      #2;
      chk(opa_ready == 1'b1 && opb_ready == 1'b0, "R10 channel A first",
          {opa_ready, opb_ready}, 64'd2);
      wait_accept(0);
      wait_accept(1);
      send(1, 8'd40, 32'd1);
      send(0, 8'd41, 32'd2);
      drain("R10");

      // R8 backpressure
      cur_req = "R8";
      res_ready = 2'b00;
      send(0, 8'd30, 32'hAAAA_0000);
      send(1, 8'd30, 32'h0000_5555);
      send(0, 8'd31, 32'd1);
      present(1, 8'd31, 32'd2);
      #2;
      chk(opb_ready == 1'b0, "R8 firing token stalled", 64'(opb_ready), 64'd0);
      begin
         logic [DATA_W-1:0] held;
         held = res_data;
         repeat (3) @(negedge clk);
         #2;
         chk(res_data == held && res_valid == 2'b11, "R8 result held",
             64'(res_data), 64'(held));
      end
      res_ready = 2'b01;
      @(negedge clk); @(negedge clk); #2;
      chk(res_valid == 2'b10 && opb_ready == 1'b0, "R8 partial take keeps stall",
          {res_valid, opb_ready}, 64'd4);
      res_ready = 2'b11;
      wait_accept(1);
      drain("R8");

      // R9 wave-advance with single consumer (R7 mask)
      do_reset(3'd4, 2'b01);
      cur_req = "R9";
      send(0, 8'hFF, 32'hDEAD_BEEF);
      send(1, 8'd3, 32'h0000_0042);
      send(0, 8'd3, 32'h0000_0043);
      drain("R9");
      chk(res_valid[1] == 1'b0, "R7 masked link silent", 64'(res_valid), 64'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule